// File: doc/BRIEF.md
# Display Refresh Address Remapper

This block turns the 16-bit memory offset produced by the display refresh logic into the linear address of one byte in a four-plane video memory, and returns the byte read from there. Two compatibility rewrites are applied to the offset, in a fixed order. First, when the controller fetches in word mode, address bit 0 is replaced by a higher address bit, so that a byte interleave across even and odd locations can be emulated. Second, one or both of address bits 13 and 14 may be replaced by the two lowest bits of the character row scan counter, which splits the frame buffer into banks for modes that store scan lines in separate regions of memory.

The rewritten offset is joined with the plane number to form the linear address, which is the plane number placed above the 16 offset bits. That address is compared with the installed memory size. A request that falls outside the installed memory, or any request when the memory size is zero, issues no memory read and returns a zero byte. Address forming and the range check are combinational. The memory answers one cycle later, and the range result is carried along with it so the zero substitution lines up with the returned data.

Top module: `vid_addr_remap`

## Requirements
- R1: With `word_mode` low, the wrap step leaves all 16 offset bits unchanged.
- R2: With `word_mode` high and `wrap_hi` high, patched bit 0 equals offset bit 15; bits 15..1 are unchanged by this step.
- R3: With `word_mode` high and `wrap_hi` low, patched bit 0 equals offset bit 13; bits 15..1 are unchanged by this step.
- R4: With `keep_a13` low, patched bit 13 equals `row_scan_lo[0]`; with it high, bit 13 passes through from the wrap step.
- R5: With `keep_a14` low, patched bit 14 equals `row_scan_lo[1]`; with it high, bit 14 passes through from the wrap step.
- R6: The wrap step sees the offset before row scan substitution, so bit 0 taken from bit 13 is the original offset bit 13 even when `keep_a13` is low.
- R7: `mem_addr` equals `plane` times 65536 plus the patched offset, in the same cycle as the request.
- R8: A request in cycle t gives `rd_valid` high in cycle t+1 with the read byte on `rd_data`; a cycle without a request gives `rd_valid` low in the next cycle.
- R9: When `mem_addr` is at or above `mem_size`, `mem_rd_en` stays low and the returned byte is 0.
- R10: When `mem_size` is 0, no request reads memory and every returned byte is 0.
- R11: While `rst_n` is low, `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Refresh read request this cycle |
| offset | input | 16 | Refresh memory offset |
| plane | input | 2 | Memory plane number |
| row_scan_lo | input | 2 | Bits 1..0 of the row scan counter |
| word_mode | input | 1 | Word-mode fetch enables the bit 0 rewrite |
| wrap_hi | input | 1 | In word mode: 1 takes bit 15, 0 takes bit 13 into bit 0 |
| keep_a13 | input | 1 | 0 replaces address bit 13 with row scan bit 0 |
| keep_a14 | input | 1 | 0 replaces address bit 14 with row scan bit 1 |
| mem_size | input | 19 | Installed memory size in bytes |
| mem_rd_en | output | 1 | Memory read strobe, only for in-range requests |
| mem_addr | output | 18 | Linear memory address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the strobe |
| rd_valid | output | 1 | Returned byte is valid |
| rd_data | output | 8 | Returned byte, 0 for out-of-range requests |

## Verification
The address and the read strobe are due in the same cycle as the request, so the bench drives a request at a falling edge and samples `mem_addr` and `mem_rd_en` one nanosecond later, before the next rising edge. The returned byte is due one rising edge later, so it is sampled at the following falling edge, which is also where the next request is driven; back-to-back requests are therefore checked in a stream with each result matched to the request one cycle earlier. Idle cycles are checked the same way for a low `rd_valid`.

// File: rtl/vremap_pkg.sv
package vremap_pkg;

  // Bit positions that the compatibility rewrites act on.
  localparam int unsigned ROW_POS_A   = 13;
  localparam int unsigned ROW_POS_B   = 14;
  localparam int unsigned WRAP_LO_SRC = 13;

  typedef struct packed {
    logic word_mode;
    logic wrap_hi;
    logic keep_a13;
    logic keep_a14;
  } remap_ctl_t;

endpackage

// File: rtl/vremap_wrap.sv
module vremap_wrap #(
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned LO_SRC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] ofs_in,
  input  logic             word_mode,
  input  logic             wrap_hi,
  output logic [OFS_W-1:0] ofs_out
);
  localparam int unsigned HI_SRC = OFS_W - 1;

  function automatic logic [OFS_W-1:0] word_wrap(
    input logic [OFS_W-1:0] a, input logic wm, input logic hi);
    logic [OFS_W-1:0] r;
    r = a;
    if (wm) r[0] = hi ? a[HI_SRC] : a[LO_SRC];
    return r;
  endfunction

  assign ofs_out = word_wrap(ofs_in, word_mode, wrap_hi);

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> ofs_out == ofs_in);
  assert_hi_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_mode && wrap_hi) |-> (ofs_out[0] == ofs_in[HI_SRC] &&
                                ofs_out[OFS_W-1:1] == ofs_in[OFS_W-1:1]));
  assert_lo_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_mode && !wrap_hi) |-> (ofs_out[0] == ofs_in[LO_SRC] &&
                                 ofs_out[OFS_W-1:1] == ofs_in[OFS_W-1:1]));
endmodule

// File: rtl/vremap_rowsub.sv
module vremap_rowsub #(
  parameter int unsigned OFS_W = 16,
  parameter int unsigned POS_A = 13,
  parameter int unsigned POS_B = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] ofs_in,
  input  logic [1:0]       row_lsb,
  input  logic             keep_a,
  input  logic             keep_b,
  output logic [OFS_W-1:0] ofs_out
);
  function automatic logic [OFS_W-1:0] row_patch(
    input logic [OFS_W-1:0] a, input logic [1:0] row,
    input logic ka, input logic kb);
    logic [OFS_W-1:0] r;
    r = a;
    if (!ka) r[POS_A] = row[0];
    if (!kb) r[POS_B] = row[1];
    return r;
  endfunction

  assign ofs_out = row_patch(ofs_in, row_lsb, keep_a, keep_b);

  assert_a13_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_out[POS_A] == (keep_a ? ofs_in[POS_A] : row_lsb[0]));
  assert_a14_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_out[POS_B] == (keep_b ? ofs_in[POS_B] : row_lsb[1]));
endmodule

// File: rtl/vremap_bound.sv
module vremap_bound #(
  parameter int unsigned LIN_W  = 18,
  parameter int unsigned SIZE_W = 19
) (
  input  logic [LIN_W-1:0]  lin_addr,
  input  logic [SIZE_W-1:0] mem_size,
  output logic              in_range
);
  localparam int unsigned PAD = SIZE_W - LIN_W;

  function automatic logic fits(
    input logic [LIN_W-1:0] a, input logic [SIZE_W-1:0] sz);
    return (sz != '0) && ({{PAD{1'b0}}, a} < sz);
  endfunction

  assign in_range = fits(lin_addr, mem_size);
endmodule

// File: rtl/vid_addr_remap.sv
module vid_addr_remap #(
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned PLANE_W = 2,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned LIN_W  = OFS_W + PLANE_W,
  localparam int unsigned SIZE_W = LIN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OFS_W-1:0]  offset,
  input  logic [PLANE_W-1:0] plane,
  input  logic [1:0]        row_scan_lo,
  input  logic              word_mode,
  input  logic              wrap_hi,
  input  logic              keep_a13,
  input  logic              keep_a14,
  input  logic [SIZE_W-1:0] mem_size,
  output logic              mem_rd_en,
  output logic [LIN_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  import vremap_pkg::*;

  remap_ctl_t       ctl;
  logic [OFS_W-1:0] wrapped_ofs;
  logic [OFS_W-1:0] patched_ofs;
  logic             addr_ok;
  logic             valid_q;
  logic             hit_q;

  assign ctl = '{word_mode: word_mode, wrap_hi: wrap_hi,
                 keep_a13: keep_a13, keep_a14: keep_a14};

  // Step 1: word-mode rewrite of bit 0.
  vremap_wrap #(.OFS_W(OFS_W), .LO_SRC(WRAP_LO_SRC)) u_wrap (
    .clk(clk), .rst_n(rst_n), .ofs_in(offset),
    .word_mode(ctl.word_mode), .wrap_hi(ctl.wrap_hi), .ofs_out(wrapped_ofs));

  // Step 2: row scan bits into the bank-select bits.
  vremap_rowsub #(.OFS_W(OFS_W), .POS_A(ROW_POS_A), .POS_B(ROW_POS_B)) u_rowsub (
    .clk(clk), .rst_n(rst_n), .ofs_in(wrapped_ofs), .row_lsb(row_scan_lo),
    .keep_a(ctl.keep_a13), .keep_b(ctl.keep_a14), .ofs_out(patched_ofs));

  function automatic logic [LIN_W-1:0] join_plane(
    input logic [PLANE_W-1:0] p, input logic [OFS_W-1:0] o);
    return {p, o};
  endfunction

  assign mem_addr = join_plane(plane, patched_ofs);

  vremap_bound #(.LIN_W(LIN_W), .SIZE_W(SIZE_W)) u_bound (
    .lin_addr(mem_addr), .mem_size(mem_size), .in_range(addr_ok));

  assign mem_rd_en = req_valid && addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= req_valid;
      hit_q   <= req_valid && addr_ok;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = hit_q ? mem_rdata : '0;

  assert_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_mode && !wrap_hi) |-> mem_addr[0] == offset[WRAP_LO_SRC]);
  assert_plane_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[LIN_W-1:OFS_W] == plane);
  assert_data_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rd_valid);
  assert_idle_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rd_valid);
  assert_no_oob_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ({1'b0, mem_addr} < mem_size));
  assert_oob_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mem_rd_en) |=> rd_data == '0);
  assert_zero_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_size == '0) |-> !mem_rd_en);
  always_comb begin
    if (!rst_n) assert_reset_idle_R11: assert (!rd_valid);
  end
endmodule

// File: tb/tb_vid_addr_remap.sv
module tb_vid_addr_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] offset = '0;
  logic [1:0]  plane = '0;
  logic [1:0]  row_scan_lo = '0;
  logic        word_mode = 1'b0;
  logic        wrap_hi = 1'b0;
  logic        keep_a13 = 1'b1;
  logic        keep_a14 = 1'b1;
  logic [18:0] mem_size = 19'h40000;
  logic        mem_rd_en;
  logic [17:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  vid_addr_remap dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .offset(offset),
    .plane(plane), .row_scan_lo(row_scan_lo), .word_mode(word_mode),
    .wrap_hi(wrap_hi), .keep_a13(keep_a13), .keep_a14(keep_a14),
    .mem_size(mem_size), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic logic [7:0] mem_fn(input logic [17:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ {a[17:16], 6'h2d};
  endfunction

  // Bench memory: one cycle read latency.
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_fn(mem_addr);

  function automatic logic [17:0] exp_addr(
    input logic [15:0] o, input logic [1:0] p, input logic [1:0] row,
    input logic wm, input logic hi, input logic k13, input logic k14);
    logic [15:0] t;
    int unsigned lin;
    t = o;
    if (wm && hi)  t[0] = o[15];
    if (wm && !hi) t[0] = o[13];
    if (!k13) t[13] = row[0];
    if (!k14) t[14] = row[1];
    lin = p * 65536 + t;
    return lin[17:0];
  endfunction

  function automatic logic exp_hit(input logic [17:0] a, input logic [18:0] sz);
    if (sz == 0) return 1'b0;
    return int'(a) < int'(sz);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Pending result from the previous cycle.
  logic        pend = 1'b0;
  logic [7:0]  pend_data = '0;
  string       pend_tag = "R8";

  task automatic settle_prev();
    if (pend) begin
      check(pend_tag, "rd_valid", {31'b0, rd_valid}, 32'd1);
      check(pend_tag, "rd_data", {24'b0, rd_data}, {24'b0, pend_data});
    end else begin
      check("R8", "idle rd_valid", {31'b0, rd_valid}, 32'd0);
    end
  endtask

  task automatic apply(input string tag, input logic [15:0] o, input logic [1:0] p,
                       input logic [1:0] row, input logic wm, input logic hi,
                       input logic k13, input logic k14, input logic [18:0] sz);
    logic [17:0] ea;
    logic eh;
    @(negedge clk);
    settle_prev();
    req_valid = 1'b1; offset = o; plane = p; row_scan_lo = row;
    word_mode = wm; wrap_hi = hi; keep_a13 = k13; keep_a14 = k14; mem_size = sz;
    ea = exp_addr(o, p, row, wm, hi, k13, k14);
    eh = exp_hit(ea, sz);
    #1;
    check(tag, "mem_addr", {14'b0, mem_addr}, {14'b0, ea});
    check(tag, "mem_rd_en", {31'b0, mem_rd_en}, {31'b0, eh});
    pend = 1'b1;
    pend_data = eh ? mem_fn(ea) : 8'h00;
    pend_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    settle_prev();
    req_valid = 1'b0;
    pend = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0413));
    repeat (3) @(negedge clk);
    check("R11", "rd_valid in reset", {31'b0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    idle();
    // Directed corners
    apply("R1", 16'hA5C3, 2'd1, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 19'h40000);
    apply("R2", 16'h8000, 2'd0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 19'h40000);
    apply("R2", 16'h7FFF, 2'd2, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 19'h40000);
    apply("R3", 16'h2000, 2'd3, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 19'h40000);
    apply("R3", 16'hDFFF, 2'd1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 19'h40000);
    apply("R4", 16'h0000, 2'd0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 19'h40000);
    apply("R4", 16'hFFFF, 2'd0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 19'h40000);
    apply("R5", 16'h0000, 2'd1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 19'h40000);
    apply("R5", 16'hFFFF, 2'd1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 19'h40000);
    // bit 13 set in offset, row bit 0 low: bit 0 must still come out 1
    apply("R6", 16'h2000, 2'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 19'h40000);
    apply("R6", 16'h0001, 2'd0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 19'h40000);
    idle();
    apply("R7", 16'h1234, 2'd3, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 19'h40000);
    apply("R9", 16'h0000, 2'd1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 19'h10000);
    apply("R9", 16'hFFFF, 2'd0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 19'h10000);
    apply("R9", 16'hFFFE, 2'd3, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 19'h3FFFF);
    apply("R9", 16'hFFFF, 2'd3, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 19'h3FFFF);
    apply("R10", 16'h0000, 2'd0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 19'h00000);
    apply("R10", 16'h4321, 2'd2, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 19'h00000);
    idle();
    idle();
    // Constrained random stream
    for (int i = 0; i < 400; i++) begin
      logic [18:0] sz;
      case ($urandom_range(0, 5))
        0: sz = 19'h00000;
        1: sz = 19'h10000;
        2: sz = 19'h20000;
        default: sz = ($urandom_range(0, 3) == 0) ? 19'($urandom_range(1, 262144))
                                                  : 19'h40000;
      endcase
      if ($urandom_range(0, 7) == 0) idle();
      else apply("R7", 16'($urandom), 2'($urandom), 2'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), sz);
    end
    idle();
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule